// File: doc/BRIEF.md
# Flash Reset and Recovery Sequencer

This block drives the active-low reset pin of a parallel flash device and decides when a host may issue writes or reads to that device. It holds the reset pin low while the supply is not good. It times a minimum low pulse for every reset, whether the reset comes from power-up or from a software request. When the flash was busy with an embedded program, erase or lock-bit operation at the start of a reset, the pin stays low for an extra abort window.

After the pin is released, two recovery windows of different lengths run from the same release edge. A write permission flag opens when the write recovery window has passed. A read permission flag opens when the read recovery window has passed. The block reports ready once both are open. A software reset request that arrives while the block is not ready is remembered. It is carried out as soon as the block next becomes ready. All durations are parameters in clock cycles, and each must be at least 1.

Top module: `flash_reset_sequencer`

## Requirements
- R1: While rst_n is low, and afterwards for as long as supply_ok stays low, flash_rp_n, wr_allow, rd_allow and ready are all 0.
- R2: In the cycle after any clock edge that samples supply_ok low, flash_rp_n, wr_allow, rd_allow and ready are all 0, whatever the previous state was.
- R3: After power-up, flash_rp_n stays low for the cycle in which supply_ok is first sampled high, then for PULSE_CYC further cycles (plus ABORT_CYC when R5 applies).
- R4: A software reset request sampled while ready is 1 drives flash_rp_n low from the next cycle, for exactly PULSE_CYC cycles when emb_busy is 0.
- R5: When emb_busy is 1 as a reset starts or during its minimum pulse, the low time of flash_rp_n grows by exactly ABORT_CYC cycles.
- R6: wr_allow rises exactly WR_REC_CYC cycles after flash_rp_n rises. The first high cycle counts as 0.
- R7: rd_allow rises exactly RD_REC_CYC cycles after flash_rp_n rises, independently of wr_allow.
- R8: ready rises max(WR_REC_CYC, RD_REC_CYC) cycles after flash_rp_n rises, and wr_allow, rd_allow and ready are all 0 whenever flash_rp_n is 0.
- R9: A software reset request sampled while ready is 0 is latched. When ready next rises, it stays high for exactly one cycle and then a new reset starts.
- R10: emb_busy high while ready is 1 has no effect: flash_rp_n and ready stay 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply is within range and stable |
| sw_rst_req | input | 1 | Software reset request, one or more cycles |
| emb_busy | input | 1 | Flash embedded program/erase/lock operation running |
| flash_rp_n | output | 1 | Active-low reset pin to the flash |
| wr_allow | output | 1 | Host may start write cycles |
| rd_allow | output | 1 | Host may start read cycles |
| ready | output | 1 | Both recovery windows have passed |

## Verification
The assertions assume that supply_ok, sw_rst_req and emb_busy are synchronous to clk. They also assume that emb_busy describes the flash's real state at the moment a reset begins, so that a captured busy flag correctly lengthens the pulse. The stimulus changes inputs only on falling clock edges. It holds emb_busy constant through each reset episode and sweeps it together with the moment a pending request arrives. Two instances with opposite orderings of the write and read recovery windows receive the same inputs, so both ordering cases are checked against the same arithmetic.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

  // Sequencer states; ordering carries no meaning outside the block.
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,  // supply not good, pin held low
    ST_HOLD    = 3'd1,  // minimum low pulse
    ST_ABORT   = 3'd2,  // extra low time for an interrupted embedded operation
    ST_RECOVER = 3'd3,  // pin high, recovery windows running
    ST_READY   = 3'd4   // both windows passed
  } frs_state_e;

  localparam int unsigned FRS_GATES = 2;  // index 0 write, index 1 read

endpackage

// File: rtl/frs_span_timer.sv
module frs_span_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] span
);

  logic [CW-1:0] span_d;
  logic          span_en;

  // Count cycles spent in the current state; restart to zero on a state change
  // and saturate so a long stay cannot wrap.
  always_comb begin
    span_en = restart || (span != {CW{1'b1}});
    span_d  = restart ? '0 : span + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span <= '0;
    end else if (span_en) begin
      span <= span_d;
    end
  end

endmodule

// File: rtl/frs_threshold_gate.sv
module frs_threshold_gate #(
  parameter int unsigned CW     = 8,
  parameter int unsigned THRESH = 1
) (
  input  logic [CW-1:0] span,
  input  logic          window,
  input  logic          hold_open,
  output logic          open_o
);

  localparam logic [CW-1:0] THRESH_W = CW'(THRESH);

  // Opens once the recovery span has reached its threshold, and stays open
  // while the sequencer is in its final state.
  always_comb begin
    open_o = hold_open || (window && (span >= THRESH_W));
  end

endmodule

// File: rtl/frs_request_latch.sv
module frs_request_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic service,
  output logic pending
);

  logic pending_d;

  // A request is remembered until the cycle in which it is served.
  always_comb begin
    if (service) begin
      pending_d = 1'b0;
    end else begin
      pending_d = pending || req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else begin
      pending <= pending_d;
    end
  end

endmodule

// File: rtl/flash_reset_sequencer.sv
module flash_reset_sequencer
  import flash_rst_pkg::*;
#(
  parameter int unsigned PULSE_CYC  = 13,
  parameter int unsigned ABORT_CYC  = 2688,
  parameter int unsigned WR_REC_CYC = 125,
  parameter int unsigned RD_REC_CYC = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic sw_rst_req,
  input  logic emb_busy,
  output logic flash_rp_n,
  output logic wr_allow,
  output logic rd_allow,
  output logic ready
);

  localparam int unsigned REC_CYC = (WR_REC_CYC > RD_REC_CYC) ? WR_REC_CYC : RD_REC_CYC;
  localparam int unsigned MAX_A   = (PULSE_CYC > ABORT_CYC) ? PULSE_CYC : ABORT_CYC;
  localparam int unsigned TOP_CYC = (MAX_A > REC_CYC) ? MAX_A : REC_CYC;
  localparam int unsigned CW      = $clog2(TOP_CYC + 1);

  localparam logic [CW-1:0] HOLD_LAST  = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] ABORT_LAST = CW'(ABORT_CYC - 1);
  localparam logic [CW-1:0] REC_LAST   = CW'(REC_CYC - 1);

  frs_state_e    state_q, state_d;
  logic          busy_q, busy_d;
  logic          restart;
  logic [CW-1:0] span;
  logic          pending;
  logic          in_recover;
  logic [FRS_GATES-1:0] gate_open;

  // ---------------------------------------------------------------- timer
  frs_span_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .span    (span)
  );

  // ------------------------------------------------------ request latch
  frs_request_latch u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (sw_rst_req),
    .service (state_q == ST_READY),
    .pending (pending)
  );

  // ------------------------------------------------------- next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:     if (supply_ok) state_d = ST_HOLD;
      ST_HOLD:    if (span == HOLD_LAST)
                    state_d = (busy_q || emb_busy) ? ST_ABORT : ST_RECOVER;
      ST_ABORT:   if (span == ABORT_LAST) state_d = ST_RECOVER;
      ST_RECOVER: if (span == REC_LAST) state_d = ST_READY;
      ST_READY:   if (pending || sw_rst_req) state_d = ST_HOLD;
      default:    state_d = ST_OFF;
    endcase
    if (!supply_ok) begin
      state_d = ST_OFF;
    end
  end

  // Busy capture: loaded as a reset starts, accumulated during the pulse.
  always_comb begin
    busy_d = busy_q;
    if (state_d == ST_HOLD && state_q != ST_HOLD) begin
      busy_d = emb_busy;
    end else if (state_q == ST_HOLD) begin
      busy_d = busy_q || emb_busy;
    end
  end

  always_comb begin
    restart = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
    end
  end

  // ---------------------------------------------------- recovery gates
  always_comb begin
    in_recover = (state_q == ST_RECOVER);
  end

  for (genvar g = 0; g < FRS_GATES; g++) begin : g_gate
    frs_threshold_gate #(
      .CW     (CW),
      .THRESH ((g == 0) ? WR_REC_CYC : RD_REC_CYC)
    ) u_gate (
      .span      (span),
      .window    (in_recover),
      .hold_open (state_q == ST_READY),
      .open_o    (gate_open[g])
    );
  end

  // ---------------------------------------------------------- outputs
  always_comb begin
    flash_rp_n = (state_q == ST_RECOVER) || (state_q == ST_READY);
    ready      = (state_q == ST_READY);
    wr_allow   = gate_open[0];
    rd_allow   = gate_open[1];
  end

  // ------------------------------------------------------- assertions
  // Run-length counters of the pin level, kept for the properties below.
  logic [CW:0] low_run, high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      if (flash_rp_n) begin
        low_run <= '0;
        if (high_run != {(CW+1){1'b1}}) high_run <= high_run + 1'b1;
      end else begin
        high_run <= '0;
        if (low_run != {(CW+1){1'b1}}) low_run <= low_run + 1'b1;
      end
    end
  end

  // R2
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!flash_rp_n && !wr_allow && !rd_allow && !ready));

  // R4
  min_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_rp_n) |-> (low_run >= (CW+1)'(PULSE_CYC)));

  // R5
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flash_rp_n) && busy_q) |-> (low_run >= (CW+1)'(PULSE_CYC + ABORT_CYC)));

  // R6
  wr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_allow) |-> (high_run == (CW+1)'(WR_REC_CYC)));

  // R7
  rd_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_allow) |-> (high_run == (CW+1)'(RD_REC_CYC)));

  // R8
  ready_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (high_run == (CW+1)'(REC_CYC)));

  // R9
  pending_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pending) |=> !flash_rp_n);

endmodule

// File: tb/flash_reset_sequencer_test.sv
`timescale 1ns/1ps
module flash_reset_sequencer_test;

  localparam int PULSE = 3;
  localparam int ABORT = 6;
  localparam int WR0 = 5, RD0 = 2;
  localparam int WR1 = 2, RD1 = 4;

  logic clk = 1'b0;
  logic rst_n, supply_ok, sw_rst_req, emb_busy;
  logic rp [2];
  logic wa [2];
  logic ra [2];
  logic rdy [2];
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  flash_reset_sequencer #(.PULSE_CYC(PULSE), .ABORT_CYC(ABORT),
                          .WR_REC_CYC(WR0), .RD_REC_CYC(RD0)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sw_rst_req(sw_rst_req),
    .emb_busy(emb_busy), .flash_rp_n(rp[0]), .wr_allow(wa[0]), .rd_allow(ra[0]),
    .ready(rdy[0]));

  flash_reset_sequencer #(.PULSE_CYC(PULSE), .ABORT_CYC(ABORT),
                          .WR_REC_CYC(WR1), .RD_REC_CYC(RD1)) uut2 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sw_rst_req(sw_rst_req),
    .emb_busy(emb_busy), .flash_rp_n(rp[1]), .wr_allow(wa[1]), .rd_allow(ra[1]),
    .ready(rdy[1]));

  function automatic int wr_of(int i);
    return (i == 0) ? WR0 : WR1;
  endfunction
  function automatic int rd_of(int i);
    return (i == 0) ? RD0 : RD1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic all_low(string req, string what);
    for (int i = 0; i < 2; i++) begin
      int v;
      v = {29'd0, rp[i], wa[i], ra[i]} * 2 + int'(rdy[i]);
      check(v == 0, req, what, v, 0);
    end
  endtask

  // Starts at the falling edge holding the first expected low sample.
  task automatic measure(string req, int exp_low, int pend_at);
    int low [2], wat [2], rat [2], yat [2], ylen [2], low2 [2], ph [2], k [2], leak [2];
    for (int i = 0; i < 2; i++) begin
      low[i] = 0; wat[i] = -1; rat[i] = -1; yat[i] = -1; ylen[i] = 0;
      low2[i] = 0; ph[i] = 0; k[i] = 0; leak[i] = 0;
    end
    for (int cyc = 0; cyc < 80; cyc++) begin
      for (int i = 0; i < 2; i++) begin
        if (ph[i] == 0) begin
          if (!rp[i]) begin
            low[i]++;
            if (wa[i] || ra[i] || rdy[i]) leak[i]++;
          end else begin
            ph[i] = 1; k[i] = 0;
          end
        end else if (ph[i] == 1) begin
          k[i]++;
        end
        if (ph[i] == 1) begin
          if (wa[i] && wat[i] < 0) wat[i] = k[i];
          if (ra[i] && rat[i] < 0) rat[i] = k[i];
          if (rdy[i]) begin yat[i] = k[i]; ph[i] = 2; end
        end
        if (ph[i] == 2) begin
          if (rdy[i]) ylen[i]++; else ph[i] = 3;
        end
        if (ph[i] == 3) begin
          if (!rp[i]) begin
            low2[i]++;
            if (wa[i] || ra[i] || rdy[i]) leak[i]++;
          end else begin
            ph[i] = 4;
          end
        end
      end
      if (cyc == pend_at) sw_rst_req = 1'b1;
      if (cyc == pend_at + 1) sw_rst_req = 1'b0;
      @(negedge clk);
    end
    for (int i = 0; i < 2; i++) begin
      int mx;
      mx = (wr_of(i) > rd_of(i)) ? wr_of(i) : rd_of(i);
      check(low[i] == exp_low, req, "pin low cycles", low[i], exp_low);
      check(leak[i] == 0, "R8", "access flags while pin low", leak[i], 0);
      check(wat[i] == wr_of(i), "R6", "write open offset", wat[i], wr_of(i));
      check(rat[i] == rd_of(i), "R7", "read open offset", rat[i], rd_of(i));
      check(yat[i] == mx, "R8", "ready offset", yat[i], mx);
      if (pend_at >= 0) begin
        check(ylen[i] == 1, "R9", "ready length before pending reset", ylen[i], 1);
        check(low2[i] == exp_low, "R9", "pending reset low cycles", low2[i], exp_low);
      end else begin
        check(ph[i] == 2, "R8", "ready held at end", ph[i], 2);
      end
    end
  endtask

  task automatic sw_trigger();
    sw_rst_req = 1'b1;
    @(negedge clk);
    sw_rst_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run incomplete actual=%0d expected=%0d", 20000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; sw_rst_req = 1'b0; emb_busy = 1'b0;
    repeat (3) @(negedge clk);
    all_low("R1", "outputs in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    all_low("R1", "outputs with supply low");

    // R3: plain power-up
    supply_ok = 1'b1;
    measure("R3", 1 + PULSE, -1);

    // R10: busy while ready changes nothing
    emb_busy = 1'b1;
    begin
      int bad = 0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (!rp[0] || !rp[1] || !rdy[0] || !rdy[1]) bad++;
      end
      check(bad == 0, "R10", "pin or ready disturbed by busy", bad, 0);
    end
    emb_busy = 1'b0;

    // R4, R5, R9: sweep busy and arrival of a pending request
    for (int b = 0; b < 2; b++) begin
      for (int p = -1; p <= 2; p++) begin
        emb_busy = b[0];
        sw_trigger();
        measure(b != 0 ? "R5" : "R4", PULSE + b * ABORT, p);
        emb_busy = 1'b0;
        repeat (30) @(negedge clk);
      end
    end

    // R2: supply lost while ready
    supply_ok = 1'b0;
    @(negedge clk);
    all_low("R2", "outputs after drop in ready");
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    measure("R3", 1 + PULSE, -1);

    // R2: supply lost during recovery
    sw_trigger();
    repeat (PULSE + 1) @(negedge clk);
    check(rp[0] && !rdy[0], "R2", "in recovery before drop", int'(rp[0]), 1);
    supply_ok = 1'b0;
    @(negedge clk);
    all_low("R2", "outputs after drop in recovery");

    // R5: power-up with an embedded operation flagged
    emb_busy = 1'b1;
    repeat (2) @(negedge clk);
    supply_ok = 1'b1;
    measure("R5", 1 + PULSE + ABORT, -1);
    emb_busy = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule